// File: doc/BRIEF.md
# DMA Command Descriptor Generator

This block turns one transfer request into the complete word stream of a DMA command. A request carries a transfer kind, a source-side address, a destination-side address, a byte count and a caller-supplied header word. The block first works out how many pointer segments each side needs. It then emits the header with both segment counts filled in, followed by the first-pointer list and then the last-pointer list. Each list is in either the local-memory pointer format or the grouped bus-address format, chosen by the transfer kind.

Words leave on a valid/ready stream. When the final word is accepted, a one-cycle done pulse reports the total word count, so that the caller can ring the engine's doorbell with it. A request that cannot be encoded produces no words. Instead it gets a done pulse with the error flag set. Such requests include an empty transfer, a count that does not fit its header field, or a command that breaks the optional length limits.

Top module: `dmagen_top`

## Requirements
- R1: The first word of every accepted command is the header: `req_hdr` with bits [5:0] replaced by the first-list segment count and bits [11:6] replaced by the last-list segment count, all other bits unchanged.
- R2: A local-format list splits the transfer into chunks of 8191 bytes, the final chunk taking the remainder; each chunk is one word with bits [63:61] zero, the chunk byte count in bits [60:48] and the address in bits [47:0].
- R3: A bus-format list splits the transfer into chunks of 65535 bytes, the final chunk taking the remainder; each chunk address is one word holding the address zero-extended to 64 bits.
- R4: Bus-format addresses come in groups of at most four, each group preceded by one length word holding slot lengths len0 in bits [15:0], len1 in [31:16], len2 in [47:32] and len3 in [63:48]; slots with no chunk are zero.
- R5: A bus-format list of N segments takes N + (N-1)/4 + 1 words (integer division); a local list of N segments takes N words.
- R6: Kind 0 (memory to memory) uses the local format for both lists.
- R7: Kinds 1 and 2 (into and out of memory) use the local format for the first list and the bus format for the last list.
- R8: Kind 3 (bus to bus) uses the bus format for both lists.
- R9: Within a list, each chunk's address is the previous chunk's address plus the previous chunk's byte count.
- R10: While `limit_chk` is high, a request whose first count exceeds 11, whose last count exceeds 11, or whose counts sum to more than 15 is rejected; while it is low such a request is accepted.
- R11: A zero-byte request, or one whose segment count exceeds 63 on either side, is rejected: no word is emitted and `done` pulses once with `done_err` high and `done_words` zero.
- R12: `done` pulses for exactly one cycle, in the cycle the final word is accepted, with `done_words` equal to the total words emitted including the header.
- R13: While `out_valid` is high and `out_ready` low, `out_valid` and `out_data` hold; `req_ready` is high only when no command is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_kind | input | 2 | Transfer kind: 0 memory-memory, 1 into memory, 2 out of memory, 3 bus-bus |
| req_first_addr | input | ADDR_W | Start address of the first-pointer side |
| req_last_addr | input | ADDR_W | Start address of the last-pointer side |
| req_size | input | SIZE_W | Transfer length in bytes |
| req_hdr | input | 64 | Caller header word; count fields are overwritten |
| limit_chk | input | 1 | Enables the segment-count limit check |
| out_valid | output | 1 | Command word available |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | 64 | Command word |
| out_last | output | 1 | Word is the final word of the command |
| done | output | 1 | Command finished or rejected |
| done_words | output | CNT_W+2 | Total words of the finished command |
| done_err | output | 1 | Request was rejected |

## Verification
The bench builds the block with its defaults: 48-bit addresses, 20-bit sizes and 6-bit count fields. A 20-bit size reaches 64 local chunks, so the count-field overflow rejection and the largest accepted command (63 chunks per side, 127 words) can both be driven. The same width covers twelve bus segments, three full groups and more. Transfers just below, at and just above the multiples of 65535 exercise the partial-group length words and the list-length formula, and a throttled `out_ready` exercises the hold rule mid-list and at format changes.

// File: rtl/dmagen_pkg.sv
package dmagen_pkg;
  localparam int WORD_W      = 64;
  localparam int PTR_ADDR_W  = 48;
  localparam int LOCAL_SZ_W  = 13;
  localparam int BUS_LEN_W   = 16;
  localparam int LOCAL_MAX   = 8191;
  localparam int BUS_MAX     = 65535;
  localparam int GROUP_SLOTS = 4;

  typedef enum logic [1:0] {
    XF_MEM2MEM = 2'd0,
    XF_TO_MEM  = 2'd1,
    XF_FROM_MEM = 2'd2,
    XF_BUS2BUS = 2'd3
  } xfer_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_FIRST, ST_LAST, ST_REJECT
  } gen_state_e;

  // smaller of a remaining byte count and a chunk limit
  function automatic logic [31:0] clip(input logic [31:0] rem, input logic [31:0] lim);
    return (rem > lim) ? lim : rem;
  endfunction

  // number of chunks a transfer splits into for a given format
  function automatic logic [31:0] seg_count(input logic [31:0] bytes, input logic bus);
    if (bus) return (bytes + 32'd65534) / 32'd65535;
    return (bytes + 32'd8190) / 32'd8191;
  endfunction

  // words a list occupies: bus lists add one length word per group of four
  function automatic logic [31:0] list_words(input logic [31:0] segs, input logic bus);
    if (!bus || segs == 32'd0) return segs;
    return segs + ((segs - 32'd1) >> 2) + 32'd1;
  endfunction
endpackage

// File: rtl/dmagen_plan.sv
module dmagen_plan
  import dmagen_pkg::*;
#(
  parameter int SIZE_W        = 20,
  parameter int CNT_W         = 6,
  parameter int CHK_FIRST_MAX = 11,
  parameter int CHK_LAST_MAX  = 11,
  parameter int CHK_SUM_MAX   = 15,
  parameter int WCNT_W        = CNT_W + 2
) (
  input  logic [1:0]        kind,
  input  logic [SIZE_W-1:0] size,
  input  logic              limit_chk,
  output logic              first_bus,
  output logic              last_bus,
  output logic [CNT_W-1:0]  first_cnt,
  output logic [CNT_W-1:0]  last_cnt,
  output logic [WCNT_W-1:0] total_words,
  output logic              reject
);
  localparam logic [31:0] CNT_MAX = 32'((1 << CNT_W) - 1);

  logic [31:0] nf, nl, wf, wl;
  logic        ovf, lim_hit;

  assign first_bus = (kind == 2'(XF_BUS2BUS));
  assign last_bus  = (kind != 2'(XF_MEM2MEM));

  assign nf = seg_count(32'(size), first_bus);
  assign nl = seg_count(32'(size), last_bus);
  assign wf = list_words(nf, first_bus);
  assign wl = list_words(nl, last_bus);

  assign ovf     = (nf > CNT_MAX) || (nl > CNT_MAX);
  assign lim_hit = limit_chk && ((nf > 32'(CHK_FIRST_MAX)) ||
                                 (nl > 32'(CHK_LAST_MAX)) ||
                                 ((nf + nl) > 32'(CHK_SUM_MAX)));
  assign reject  = (size == '0) || ovf || lim_hit;

  assign first_cnt   = CNT_W'(nf);
  assign last_cnt    = CNT_W'(nl);
  assign total_words = WCNT_W'(32'd1 + wf + wl);
endmodule

// File: rtl/dmagen_list_walker.sv
module dmagen_list_walker
  import dmagen_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int SIZE_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              load_bus,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [SIZE_W-1:0] load_size,
  input  logic              adv,
  output logic [WORD_W-1:0] word,
  output logic              last_word
);
  localparam int SLOT_W = $clog2(GROUP_SLOTS);

  logic              bus_q, in_len_q;
  logic [SLOT_W-1:0] slot_q;
  logic [ADDR_W-1:0] addr_q;
  logic [SIZE_W-1:0] rem_q;
  logic [31:0]       rem32;
  logic [SIZE_W-1:0] chunk;
  logic [WORD_W-1:0] len_word;
  logic              len_phase;

  assign rem32     = 32'(rem_q);
  assign chunk     = SIZE_W'(clip(rem32, bus_q ? 32'(BUS_MAX) : 32'(LOCAL_MAX)));
  assign len_phase = bus_q && in_len_q;

  // one length slot per address of the upcoming group
  for (genvar k = 0; k < GROUP_SLOTS; k++) begin : g_len
    localparam logic [31:0] SKIP = 32'(k * BUS_MAX);
    assign len_word[k*BUS_LEN_W +: BUS_LEN_W] =
      BUS_LEN_W'(clip((rem32 > SKIP) ? (rem32 - SKIP) : 32'd0, 32'(BUS_MAX)));
  end

  always_comb begin
    if (!bus_q)        word = {3'b000, LOCAL_SZ_W'(chunk), PTR_ADDR_W'(addr_q)};
    else if (in_len_q) word = len_word;
    else               word = WORD_W'(addr_q);
  end

  assign last_word = bus_q ? (!in_len_q && rem32 <= 32'(BUS_MAX))
                           : (rem32 <= 32'(LOCAL_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_q    <= 1'b0;
      in_len_q <= 1'b0;
      slot_q   <= '0;
      addr_q   <= '0;
      rem_q    <= '0;
    end else if (load) begin
      bus_q    <= load_bus;
      in_len_q <= load_bus;
      slot_q   <= '0;
      addr_q   <= load_addr;
      rem_q    <= load_size;
    end else if (adv) begin
      if (len_phase) begin
        in_len_q <= 1'b0;
        slot_q   <= '0;
      end else begin
        addr_q <= addr_q + ADDR_W'(chunk);
        rem_q  <= rem_q - chunk;
        if (bus_q) begin
          slot_q <= slot_q + 1'b1;
          if (slot_q == SLOT_W'(GROUP_SLOTS - 1)) in_len_q <= 1'b1;
        end
      end
    end
  end

  AST_LEN_THEN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    adv && len_phase |=> !len_phase && !last_word == (rem_q > SIZE_W'(BUS_MAX))); // R4
  AST_CHUNK_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !len_phase |-> chunk != '0); // R2
  AST_REM_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !len_phase && !last_word |=> rem_q < $past(rem_q)); // R9
endmodule

// File: rtl/dmagen_top.sv
module dmagen_top
  import dmagen_pkg::*;
#(
  parameter int ADDR_W        = 48,
  parameter int SIZE_W        = 20,
  parameter int CNT_W         = 6,
  parameter int CHK_FIRST_MAX = 11,
  parameter int CHK_LAST_MAX  = 11,
  parameter int CHK_SUM_MAX   = 15,
  localparam int WCNT_W       = CNT_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_first_addr,
  input  logic [ADDR_W-1:0] req_last_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [63:0]       req_hdr,
  input  logic              limit_chk,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [63:0]       out_data,
  output logic              out_last,
  output logic              done,
  output logic [WCNT_W-1:0] done_words,
  output logic              done_err
);
  gen_state_e        state_q;
  logic [63:0]       hdr_q, hdr_next;
  logic [WCNT_W-1:0] words_q, sent_q;
  logic              req_fire, out_fire;

  logic              p_first_bus, p_last_bus, p_reject;
  logic [CNT_W-1:0]  p_first_cnt, p_last_cnt;
  logic [WCNT_W-1:0] p_total;

  logic [63:0]       fw_word, lw_word;
  logic              fw_last, lw_last, fw_adv, lw_adv;

  dmagen_plan #(
    .SIZE_W(SIZE_W), .CNT_W(CNT_W), .CHK_FIRST_MAX(CHK_FIRST_MAX),
    .CHK_LAST_MAX(CHK_LAST_MAX), .CHK_SUM_MAX(CHK_SUM_MAX), .WCNT_W(WCNT_W)
  ) u_plan (
    .kind(req_kind), .size(req_size), .limit_chk(limit_chk),
    .first_bus(p_first_bus), .last_bus(p_last_bus),
    .first_cnt(p_first_cnt), .last_cnt(p_last_cnt),
    .total_words(p_total), .reject(p_reject)
  );

  dmagen_list_walker #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_first (
    .clk(clk), .rst_n(rst_n), .load(req_fire), .load_bus(p_first_bus),
    .load_addr(req_first_addr), .load_size(req_size), .adv(fw_adv),
    .word(fw_word), .last_word(fw_last)
  );

  dmagen_list_walker #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_last (
    .clk(clk), .rst_n(rst_n), .load(req_fire), .load_bus(p_last_bus),
    .load_addr(req_last_addr), .load_size(req_size), .adv(lw_adv),
    .word(lw_word), .last_word(lw_last)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign req_fire  = req_valid && req_ready;

  always_comb begin
    hdr_next = req_hdr;
    hdr_next[CNT_W-1:0]       = p_first_cnt;
    hdr_next[2*CNT_W-1:CNT_W] = p_last_cnt;
  end

  assign out_valid = (state_q == ST_HDR) || (state_q == ST_FIRST) || (state_q == ST_LAST);

  always_comb begin
    case (state_q)
      ST_HDR:   out_data = hdr_q;
      ST_FIRST: out_data = fw_word;
      ST_LAST:  out_data = lw_word;
      default:  out_data = '0;
    endcase
  end

  assign out_fire   = out_valid && out_ready;
  assign fw_adv     = out_fire && (state_q == ST_FIRST);
  assign lw_adv     = out_fire && (state_q == ST_LAST);
  assign out_last   = (state_q == ST_LAST) && lw_last;
  assign done_err   = (state_q == ST_REJECT);
  assign done       = (out_fire && out_last) || done_err;
  assign done_words = done_err ? '0 : words_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hdr_q   <= '0;
      words_q <= '0;
      sent_q  <= '0;
    end else begin
      if (req_fire) begin
        hdr_q   <= hdr_next;
        words_q <= p_total;
        sent_q  <= '0;
      end else if (out_fire) begin
        sent_q  <= sent_q + 1'b1;
      end
      case (state_q)
        ST_IDLE:   if (req_fire) state_q <= p_reject ? ST_REJECT : ST_HDR;
        ST_HDR:    if (out_fire) state_q <= ST_FIRST;
        ST_FIRST:  if (out_fire && fw_last) state_q <= ST_LAST;
        ST_LAST:   if (out_fire && lw_last) state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  AST_HDR_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire && !p_reject |=> out_valid && out_data == $past(hdr_next)); // R1
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R13
  AST_DONE_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    done && !done_err |-> WCNT_W'(sent_q + 1'b1) == done_words); // R12
  AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_err |-> sent_q == '0 && !out_valid); // R11
endmodule

// File: tb/tb_dmagen_top.sv
module tb_dmagen_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, limit_chk, out_valid, out_ready, out_last;
  logic [1:0]  req_kind;
  logic [47:0] req_first_addr, req_last_addr;
  logic [19:0] req_size;
  logic [63:0] req_hdr, out_data;
  logic        done, done_err;
  logic [7:0]  done_words;

  int checks = 0;
  int errors = 0;
  logic [63:0] exp_w [0:255];
  logic [63:0] got_w [0:255];
  int exp_n, got_n;

  always #10 clk = ~clk;

  dmagen_top dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_first_addr(req_first_addr), .req_last_addr(req_last_addr),
    .req_size(req_size), .req_hdr(req_hdr), .limit_chk(limit_chk),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .done(done), .done_words(done_words), .done_err(done_err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [63:0] w);
    exp_w[exp_n] = w;
    exp_n++;
  endtask

  function automatic int segs(input int sz, input int lim);
    int n = 0;
    while (sz > 0) begin sz -= lim; n++; end
    return n;
  endfunction

  task automatic add_list(input bit bus, input logic [47:0] a0, input int sz);
    int rem = sz;
    logic [47:0] a = a0;
    if (!bus) begin
      while (rem > 0) begin
        int c = (rem > 8191) ? 8191 : rem;
        push({3'b000, 13'(c), a});
        a += 48'(c); rem -= c;
      end
    end else begin
      while (rem > 0) begin
        logic [63:0] lw = '0;
        int t = rem;
        for (int k = 0; k < 4; k++) begin
          int l = (t > 65535) ? 65535 : t;
          lw[16*k +: 16] = 16'(l); t -= l;
        end
        push(lw);
        for (int k = 0; k < 4 && rem > 0; k++) begin
          int c = (rem > 65535) ? 65535 : rem;
          push({16'h0, a});
          a += 48'(c); rem -= c;
        end
      end
    end
  endtask

  task automatic run(input string name, input string tag, input logic [1:0] kind,
                     input logic [47:0] fa, input logic [47:0] la, input int sz,
                     input bit chk, input bit stall);
    bit fbus = (kind == 2'd3);
    bit lbus = (kind != 2'd0);
    int nf = segs(sz, fbus ? 65535 : 8191);
    int nl = segs(sz, lbus ? 65535 : 8191);
    bit exp_err = (sz == 0) || nf > 63 || nl > 63 || (chk && (nf > 11 || nl > 11 || nf + nl > 15));
    int wf = fbus ? nf + (nf - 1) / 4 + 1 : nf;
    int wl = lbus ? nl + (nl - 1) / 4 + 1 : nl;
    logic [63:0] h = 64'hDEAD_BEEF_0123_4FFF;
    logic [63:0] pend_d = '0;
    bit fin = 0, pend = 0, derr = 0;
    int dones = 0;
    logic [7:0] dw = '0;
    exp_n = 0; got_n = 0;
    h[5:0] = 6'(nf); h[11:6] = 6'(nl);
    if (!exp_err) begin
      push(h); add_list(fbus, fa, sz); add_list(lbus, la, sz);
    end
    @(negedge clk);
    req_kind = kind; req_first_addr = fa; req_last_addr = la; req_size = 20'(sz);
    req_hdr = 64'hDEAD_BEEF_0123_4FFF; limit_chk = chk; req_valid = 1'b1;
    check(req_ready, "R13", {name, " ready when idle"}, 64'(req_ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int cyc = 0; cyc < 1000 && !fin; cyc++) begin
      out_ready = stall ? (cyc % 3 != 1) : 1'b1;
      #1;
      if (pend) check(out_valid && out_data == pend_d, "R13", {name, " stalled word held"}, out_data, pend_d);
      if (out_valid) check(!req_ready, "R13", {name, " busy blocks requests"}, 64'(req_ready), 64'd0);
      pend = out_valid && !out_ready; pend_d = out_data;
      if (out_valid && out_ready) begin
        if (got_n < 256) got_w[got_n] = out_data;
        got_n++;
      end
      if (done) begin dones++; dw = done_words; derr = done_err; fin = 1; end
      @(negedge clk);
    end
    #1;
    check(!done && req_ready, "R12", {name, " done is a single pulse"}, 64'(done), 64'd0);
    check(dones == 1, "R12", {name, " done seen"}, 64'(dones), 64'd1);
    check(derr == exp_err, tag, {name, " error flag"}, 64'(derr), 64'(exp_err));
    check(got_n == exp_n, tag, {name, " word count"}, 64'(got_n), 64'(exp_n));
    if (exp_err) begin
      check(dw == 8'd0, "R11", {name, " rejected word total"}, 64'(dw), 64'd0);
    end else begin
      check(dw == 8'(exp_n), "R12", {name, " done_words"}, 64'(dw), 64'(exp_n));
      if (fbus || lbus) check(dw == 8'(1 + wf + wl), "R5", {name, " list length formula"}, 64'(dw), 64'(1 + wf + wl));
      for (int i = 0; i < exp_n && i < got_n; i++)
        check(got_w[i] == exp_w[i], (i == 0) ? "R1" : tag,
              $sformatf("%s word %0d", name, i), got_w[i], exp_w[i]);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req_valid = 1'b0; out_ready = 1'b1; limit_chk = 1'b0;
    req_kind = '0; req_first_addr = '0; req_last_addr = '0; req_size = '0; req_hdr = '0;
    repeat (4) @(negedge clk);
    check(!out_valid && !done, "R12", "reset: no output, no done", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready, "R13", "reset: idle and ready", 64'(req_ready), 64'd1);
  endtask

  task automatic t_mem2mem();
    run("mem2mem small", "R6", 2'd0, 48'h1000, 48'h8000, 100, 1'b0, 1'b0);
    run("mem2mem multi", "R2,R9", 2'd0, 48'h0_1234_5670, 48'hA_0000_0003, 20000, 1'b0, 1'b1);
  endtask

  task automatic t_mixed();
    run("to-mem", "R7", 2'd1, 48'h4000_0000, 48'hF_0000_0000, 200000, 1'b0, 1'b0);
    run("from-mem partial group", "R4,R7", 2'd2, 48'h10, 48'h20_0000_0000, 327682, 1'b0, 1'b1);
  endtask

  task automatic t_bus2bus();
    run("bus2bus two segs", "R8,R4", 2'd3, 48'hABC_0000_0000, 48'h123_4567_0000, 70000, 1'b0, 1'b0);
    run("bus exact one seg", "R3", 2'd3, 48'h100, 48'h200, 65535, 1'b0, 1'b0);
    run("bus full group", "R3,R5", 2'd3, 48'h300, 48'h400, 262140, 1'b0, 1'b1);
    run("bus group spill", "R3,R5,R9", 2'd3, 48'h500, 48'h600, 262141, 1'b0, 1'b0);
  endtask

  task automatic t_limits();
    run("limit first over", "R10", 2'd0, 48'h0, 48'h0, 8191 * 12, 1'b1, 1'b0);
    run("limit sum over", "R10", 2'd0, 48'h0, 48'h0, 8191 * 8, 1'b1, 1'b0);
    run("limit sum ok", "R10", 2'd0, 48'h40, 48'h80, 8191 * 7, 1'b1, 1'b0);
    run("limit bus over", "R10", 2'd3, 48'h0, 48'h0, 65535 * 12, 1'b1, 1'b0);
    run("limit off accepts", "R10", 2'd0, 48'h40, 48'h80, 8191 * 12, 1'b0, 1'b0);
  endtask

  task automatic t_reject();
    run("zero size", "R11", 2'd1, 48'h0, 48'h0, 0, 1'b0, 1'b0);
    run("count overflow", "R11", 2'd0, 48'h0, 48'h0, 8191 * 64, 1'b0, 1'b0);
    run("largest accepted", "R11", 2'd0, 48'h7, 48'h9, 8191 * 63, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_mem2mem();
    t_mixed();
    t_bus2bus();
    t_limits();
    t_reject();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule